// File: doc/BRIEF.md
# Page Boundary Detector for a Two-Strobe External Bus

This block sits beside an external memory interface that has two independent strobe channels. Each time an access starts on a channel, the block decides whether the access lands on a different page from the previous access on that same channel. When the page changes, the block requests one inserted bus cycle, so that slow devices can release the bus or external logic can reconfigure itself. It also drives the channel's active-low page indicator to its inactive (high) level.

Each channel has its own 5-bit page-size field. A field value N makes address bits N..0 the offset within a page. Bits 30..N+1 then name the page. Values below 7 act as 7, which gives a 256-word page. Values of 30 and 31 leave no page bits at all. Each channel keeps its own record of the last address and of the page-size field used for that access. After reset, and after any change of the page-size field, the next access on the channel is always treated as a page change.

Top module: `page_boundary_detector`

## Requirements
- R1: While reset is asserted, and after reset until the first access, `insert_o` is 0 and `page_n_o` is 1 on both channels.
- R2: The first access on a channel after reset sets that channel's `insert_o` and `page_n_o` to 1 on the clock edge that samples `start_i`.
- R3: An access whose address differs from the channel's previous address only in offset bits gives `insert_o`=0 and `page_n_o`=0 on the following cycle.
- R4: An access whose address differs from the previous address in any page bit gives `insert_o`=1 and `page_n_o`=1 on the following cycle.
- R5: Page-size field value N, for N in 7..30, makes bits N..0 the offset. Field values 0..6 behave as 7. Field value 31 behaves as 30.
- R6: With a field value of 30 or 31, no access after the first one on a channel is ever a page change.
- R7: `insert_o` is high for one clock per access that changes page. In a cycle with no access start on a channel, that channel's `insert_o` is 0 on the next cycle and its `page_n_o` holds its value.
- R8: The two channels are independent. An access on one channel never changes the other channel's `insert_o`, `page_n_o` or stored page.
- R9: If a channel's page-size field differs from the value it had at that channel's previous access, the next access is a page change.
- R10: The stored last address is updated on every access, including accesses that caused an inserted cycle. The page comparison always uses the immediately preceding access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 2 | Per-channel access-start strobe, one cycle per access |
| addr_i | input | 31 | Word address of the starting access |
| psz_i | input | 2x5 | Per-channel page-size field (channel c at bits 5c+4..5c) |
| insert_o | output | 2 | Per-channel one-cycle inserted-cycle request |
| page_n_o | output | 2 | Per-channel page indicator, high after a page change, low after a same-page access |

## Verification
The bench sweeps every page-size field value. For each value it flips each of the 31 address bits in turn, which places the boundary between offset and page bits exactly. A mask that is off by one bit, or that ignores the clamping at the low or high end, would miss a page change or report a false one at that bit. Other sequences check the following: the first access after reset, a change of the page-size field at an unchanged address, and accesses that alternate between the two channels on different pages. A design that shared its state between channels, or that updated its stored address only on page changes, would insert cycles in those sequences where none belong. Idle cycles after each access show whether the inserted-cycle request lasts more than one clock.

// File: rtl/page_boundary_pkg.sv
package page_boundary_pkg;
  localparam int unsigned ADDR_W  = 31;
  localparam int unsigned PSZ_W   = 5;
  localparam int unsigned N_CH    = 2;
  localparam int unsigned MIN_OFS = 7;
endpackage

// File: rtl/page_mask_gen.sv
module page_mask_gen #(
  parameter int unsigned ADDR_W  = page_boundary_pkg::ADDR_W,
  parameter int unsigned PSZ_W   = page_boundary_pkg::PSZ_W,
  parameter int unsigned MIN_OFS = page_boundary_pkg::MIN_OFS
) (
  input  logic [PSZ_W-1:0]  psz_i,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int unsigned MAX_OFS = ADDR_W - 1;

  int unsigned eff;

  always_comb begin
    if (int'(psz_i) < int'(MIN_OFS))      eff = MIN_OFS;
    else if (int'(psz_i) > int'(MAX_OFS)) eff = MAX_OFS;
    else                                  eff = int'(psz_i);
  end

  // page bits are those strictly above the offset
  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    assign mask_o[g] = (g > eff);
  end

  always_comb begin
    assert (mask_o[MIN_OFS:0] == '0) else $error("p_min_page_r5 violated");
  end

endmodule

// File: rtl/page_channel_tracker.sv
module page_channel_tracker #(
  parameter int unsigned ADDR_W = page_boundary_pkg::ADDR_W,
  parameter int unsigned PSZ_W  = page_boundary_pkg::PSZ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PSZ_W-1:0]  psz_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              insert_o,
  output logic              page_n_o
);
  logic [ADDR_W-1:0] last_q;
  logic [PSZ_W-1:0]  psz_q;
  logic              valid_q;
  logic              change;

  assign change = !valid_q || (psz_i != psz_q) || (|((addr_i ^ last_q) & mask_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= '0;
      psz_q    <= '0;
      valid_q  <= 1'b0;
      insert_o <= 1'b0;
      page_n_o <= 1'b1;
    end else begin
      insert_o <= start_i & change;
      if (start_i) begin
        last_q   <= addr_i;
        psz_q    <= psz_i;
        valid_q  <= 1'b1;
        page_n_o <= change;
      end
    end
  end

  p_idle_no_insert_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !insert_o);
  p_idle_hold_page_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(page_n_o));
  p_insert_page_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_o |-> page_n_o);
  p_first_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_q |=> insert_o);
  p_repeat_same_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && valid_q && psz_i == psz_q && addr_i == last_q |=> !insert_o && !page_n_o);
  p_psz_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && valid_q && psz_i != psz_q |=> insert_o);

endmodule

// File: rtl/page_boundary_detector.sv
module page_boundary_detector #(
  parameter int unsigned ADDR_W  = page_boundary_pkg::ADDR_W,
  parameter int unsigned PSZ_W   = page_boundary_pkg::PSZ_W,
  parameter int unsigned N_CH    = page_boundary_pkg::N_CH,
  parameter int unsigned MIN_OFS = page_boundary_pkg::MIN_OFS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CH-1:0]            start_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [N_CH-1:0][PSZ_W-1:0] psz_i,
  output logic [N_CH-1:0]            insert_o,
  output logic [N_CH-1:0]            page_n_o
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] mask;

    page_mask_gen #(
      .ADDR_W (ADDR_W),
      .PSZ_W  (PSZ_W),
      .MIN_OFS(MIN_OFS)
    ) u_mask (
      .psz_i (psz_i[c]),
      .mask_o(mask)
    );

    page_channel_tracker #(
      .ADDR_W(ADDR_W),
      .PSZ_W (PSZ_W)
    ) u_trk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i[c]),
      .addr_i  (addr_i),
      .psz_i   (psz_i[c]),
      .mask_i  (mask),
      .insert_o(insert_o[c]),
      .page_n_o(page_n_o[c])
    );
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> insert_o == '0 && page_n_o == '1);

endmodule

// File: tb/page_boundary_detector_tb_top.sv
`timescale 1ns/1ps
module page_boundary_detector_tb_top;
  localparam int AW = 31;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       start = '0;
  logic [AW-1:0]    addr = '0;
  logic [1:0][4:0]  psz = '0;
  logic [1:0]       insert;
  logic [1:0]       page_n;

  int n_checks = 0;
  int n_fail   = 0;

  logic [AW-1:0] m_last [2];
  logic [4:0]    m_psz  [2];
  bit            m_valid[2];
  bit            m_pn   [2];

  always #2 clk = ~clk;

  page_boundary_detector dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .addr_i  (addr),
    .psz_i   (psz),
    .insert_o(insert),
    .page_n_o(page_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] page_mask(input logic [4:0] f);
    int e;
    e = (f < 7) ? 7 : ((f > 30) ? 30 : int'(f));
    if (e >= 30) return '0;
    return {AW{1'b1}} << (e + 1);
  endfunction

  function automatic bit exp_change(input int ch, input logic [AW-1:0] a);
    return !m_valid[ch] || (psz[ch] != m_psz[ch]) ||
           (((a ^ m_last[ch]) & page_mask(psz[ch])) != '0);
  endfunction

  task automatic access(input int ch, input logic [AW-1:0] a, input string req);
    bit e;
    int oc;
    oc = 1 - ch;
    e = exp_change(ch, a);
    @(negedge clk);
    addr = a;
    start[ch] = 1'b1;
    @(negedge clk);
    start = '0;
    chk(req, insert[ch], e);
    chk(req, page_n[ch], e);
    chk("R8", insert[oc], 0);
    chk("R8", page_n[oc], m_pn[oc]);
    m_last[ch] = a; m_psz[ch] = psz[ch]; m_valid[ch] = 1'b1; m_pn[ch] = e;
    @(negedge clk);
    chk("R7", insert[ch], 0);
    chk("R7", page_n[ch], e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] base;
    for (int c = 0; c < 2; c++) begin
      m_last[c] = '0; m_psz[c] = '0; m_valid[c] = 0; m_pn[c] = 1;
    end
    repeat (3) @(negedge clk);
    chk("R1", insert, 2'b00);
    chk("R1", page_n, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", insert, 2'b00);
    chk("R1", page_n, 2'b11);

    // R2: first access per channel
    psz[0] = 5'd10; psz[1] = 5'd10;
    access(0, 31'h0000_1234, "R2");
    chk("R2", m_pn[0], 1);
    access(1, 31'h0000_1234, "R2");
    chk("R2", m_pn[1], 1);

    // R3 / R4 explicit
    access(0, 31'h0000_1000, "R3");
    chk("R3", page_n[0], 0);
    access(0, 31'h0000_1800, "R4");
    chk("R4", page_n[0], 1);

    // R10: chained pages compared against previous access
    access(0, 31'h0000_2000, "R10");
    access(0, 31'h0000_27FF, "R10");
    access(0, 31'h0000_1800, "R10");

    // R9: field change at same address
    psz[0] = 5'd12;
    access(0, 31'h0000_1800, "R9");
    chk("R9", insert[0] | page_n[0], 1);
    access(0, 31'h0000_1800, "R9");

    // R8: alternating channels on different pages
    psz[0] = 5'd8; psz[1] = 5'd8;
    access(0, 31'h0100_0000, "R8");
    access(1, 31'h0200_0000, "R8");
    for (int k = 0; k < 8; k++) begin
      access(0, 31'h0100_0000 | 31'(k * 3), "R8");
      access(1, 31'h0200_0000 | 31'(k * 5), "R8");
    end

    // R5 / R6: sweep every field value and every address bit
    base = 31'h2AC3_5E17;
    for (int f = 0; f < 32; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        psz[ch] = 5'(f);
        access(ch, base, "R9");
        for (int b = 0; b < AW; b++) begin
          access(ch, base ^ (31'd1 << b), (f >= 30) ? "R6" : "R5");
          access(ch, base, (f >= 30) ? "R6" : "R5");
        end
      end
      base = {base[29:0], base[30] ^ base[27]};
    end

    // R6: far-apart addresses with the full-space page
    psz[1] = 5'd30;
    access(1, 31'h0000_0000, "R9");
    access(1, 31'h7FFF_FFFF, "R6");
    chk("R6", page_n[1], 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule